// File: doc/BRIEF.md
# Two-Bank SDRAM Command Timing Monitor

This block watches the command pins of a two-bank SDRAM and reports, in the same clock cycle, every command that breaks a row-timing rule. It never drives the memory. Each clock it decodes the chip-select, row strobe, column strobe, write enable and clock-enable pins into one command. It keeps the open or closed state of both banks, along with the cycles since each bank's last activate, last precharge and last auto-precharged write. One flag output exists for each kind of violation. All timing limits are parameters in clock cycles.

Auto-precharge is modelled explicitly. A read or write with the auto-precharge bit high opens a window of `BURST_LEN` cycles. During that window any further read, write or precharge is illegal. The bank closes by itself on the last beat of the window. A `BURST_LEN` of 0 means full-page bursts, for which auto-precharge itself is illegal.

Top module: `sdram_timing_monitor`

## Requirements
- R1: `cmd_o` encodes the decoded command while `cke` is high and `cs_n` is low. The encodings are 1 NOP ({ras_n,cas_n,we_n}=111), 2 activate (011), 3 read (101), 4 write (100), 5 precharge (010), 6 burst stop (110) and 7 any other pattern. After reset both banks are closed and no flag is raised by a NOP.
- R2: A cycle with `cs_n` high or `cke` low yields `cmd_o` = 0, raises no flag and changes no bank state.
- R3: A read or write to a bank fewer than `TRCD` cycles after that bank's activate raises `flag_rcd`.
- R4: An activate fewer than `TRC` cycles after the previous activate of the same bank raises `flag_rc`.
- R5: An activate to a bank that is still open raises `flag_reopen`.
- R6: An activate fewer than `TRRD` cycles after an activate of the other bank raises `flag_rrd`.
- R7: An activate fewer than `TRP` cycles after that bank was closed by a precharge raises `flag_rp`.
- R8: A precharge with `a10` high closes both banks. With `a10` low it closes only the bank selected by `ba`. A precharge to a closed bank leaves its timing history untouched.
- R9: A precharge that closes a bank fewer than `TRAS` cycles after its activate raises `flag_ras`.
- R10: A read or write with `a10` high starts an auto-precharge window covering the `BURST_LEN`-1 cycles after the command. A read, write or precharge to either bank inside that window raises `flag_ap_busy` and does not start a new window.
- R11: A bank with an auto-precharged read closes at the end of the window's last cycle. `flag_rp` counts `TRP` from that cycle.
- R12: After an auto-precharged write, an activate of that bank fewer than `TDPL`+`TRP` cycles after the last burst cycle raises `flag_dal`.
- R13: When `BURST_LEN` is 0 (full page), a read or write with `a10` high raises `flag_ap_fullpage` and starts no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 1 | Bank select |
| a10 | input | 1 | Auto-precharge / precharge-all bit |
| cmd_o | output | 3 | Decoded command (R1 encoding) |
| flag_rcd | output | 1 | Access too soon after activate |
| flag_rc | output | 1 | Same-bank activates too close |
| flag_rrd | output | 1 | Cross-bank activates too close |
| flag_rp | output | 1 | Activate too soon after precharge |
| flag_ras | output | 1 | Precharge too soon after activate |
| flag_dal | output | 1 | Activate too soon after auto-precharged write |
| flag_reopen | output | 1 | Activate to an open bank |
| flag_ap_busy | output | 1 | Command inside an auto-precharge window |
| flag_ap_fullpage | output | 1 | Auto-precharge requested with full-page bursts |

## Verification
The properties assume the command pins hold a benign NOP pattern while reset is high, so that the first cycle after reset has no leftover activate to compare against. They also assume the timing parameters stay at or above one. The directed stimulus drives every pin on the falling clock edge and keeps NOP during reset. It resets the monitor before each scenario so each sequence starts from two closed banks with saturated history. The back-to-back properties use these cases: two activates one cycle apart, and an access right after an activate. Each scenario builds these only where it intends the flag to rise.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE  = 3'd0,
        CMD_NOP   = 3'd1,
        CMD_ACT   = 3'd2,
        CMD_RD    = 3'd3,
        CMD_WR    = 3'd4,
        CMD_PRE   = 3'd5,
        CMD_BST   = 3'd6,
        CMD_OTHER = 3'd7
    } cmd_e;

    typedef struct packed {
        logic rcd;
        logic rc;
        logic rrd;
        logic rp;
        logic ras;
        logic dal;
        logic reopen;
        logic ap_busy;
        logic ap_fp;
    } viol_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n,
                                        input logic cke);
        if (!cke || cs_n) return CMD_IDLE;
        case ({ras_n, cas_n, we_n})
            3'b111:  return CMD_NOP;
            3'b011:  return CMD_ACT;
            3'b101:  return CMD_RD;
            3'b100:  return CMD_WR;
            3'b010:  return CMD_PRE;
            3'b110:  return CMD_BST;
            default: return CMD_OTHER;
        endcase
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    output cmd_e cmd
);

    assign cmd = decode_cmd(cs_n, ras_n, cas_n, we_n, cke);

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
    parameter int CW     = 5,
    parameter int BL_EFF = 4,
    parameter int BW     = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          act,
    input  logic          pre,
    input  logic          ap_start,
    input  logic          ap_wr,
    output logic          open,
    output logic          busy,
    output logic [CW-1:0] act_age,
    output logic [CW-1:0] pre_age,
    output logic [CW-1:0] dal_age
);

    localparam logic [CW-1:0] SAT = {CW{1'b1}};
    localparam logic [BW-1:0] LOAD = BW'(BL_EFF - 1);

    logic [BW-1:0] rem;
    logic          wr_q;
    logic          close_ap;
    logic          wr_now;

    // the window's last beat is either the command itself (single beat) or rem==1
    assign close_ap = (ap_start && (BL_EFF == 1)) || (rem == BW'(1));
    assign wr_now   = ap_start ? ap_wr : wr_q;
    assign busy     = (rem != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem     <= '0;
            wr_q    <= 1'b0;
            open    <= 1'b0;
            act_age <= SAT;
            pre_age <= SAT;
            dal_age <= SAT;
        end else begin
            if (ap_start) wr_q <= ap_wr;

            if (ap_start && (BL_EFF > 1)) rem <= LOAD;
            else if (rem != '0)           rem <= rem - BW'(1);

            if (act)                open <= 1'b1;
            else if (pre || close_ap) open <= 1'b0;

            act_age <= act ? CW'(1) : ((act_age == SAT) ? SAT : act_age + CW'(1));

            if (pre || (close_ap && !wr_now)) pre_age <= CW'(1);
            else if (pre_age != SAT)          pre_age <= pre_age + CW'(1);

            if (close_ap && wr_now)  dal_age <= CW'(1);
            else if (dal_age != SAT) dal_age <= dal_age + CW'(1);
        end
    end

endmodule

// File: rtl/sdram_timing_monitor.sv
module sdram_timing_monitor
    import sdram_mon_pkg::*;
#(
    parameter int TRCD      = 3,
    parameter int TRC       = 9,
    parameter int TRRD      = 2,
    parameter int TRP       = 3,
    parameter int TRAS      = 6,
    parameter int TDPL      = 2,
    parameter int BURST_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       cke,
    input  logic       ba,
    input  logic       a10,
    output logic [2:0] cmd_o,
    output logic       flag_rcd,
    output logic       flag_rc,
    output logic       flag_rrd,
    output logic       flag_rp,
    output logic       flag_ras,
    output logic       flag_dal,
    output logic       flag_reopen,
    output logic       flag_ap_busy,
    output logic       flag_ap_fullpage
);

    localparam bit FULL_PAGE = (BURST_LEN == 0);
    localparam int BL_EFF    = FULL_PAGE ? 1 : BURST_LEN;
    localparam int BW        = (BL_EFF > 1) ? $clog2(BL_EFF) : 1;
    localparam int TDAL      = TDPL + TRP;
    localparam int MAXT      = max_of(max_of(max_of(TRCD, TRC), max_of(TRRD, TRP)),
                                      max_of(TRAS, TDAL));
    localparam int CW        = $clog2(MAXT + 1) + 1;

    localparam logic [CW-1:0] LIM_RCD = CW'(TRCD);
    localparam logic [CW-1:0] LIM_RC  = CW'(TRC);
    localparam logic [CW-1:0] LIM_RRD = CW'(TRRD);
    localparam logic [CW-1:0] LIM_RP  = CW'(TRP);
    localparam logic [CW-1:0] LIM_RAS = CW'(TRAS);
    localparam logic [CW-1:0] LIM_DAL = CW'(TDAL);

    cmd_e cmd;
    logic is_act, is_rw, is_pre, any_busy;
    logic [1:0] open, busy, act_hit, pre_hit, ap_start;
    logic [1:0][CW-1:0] act_age, pre_age, dal_age;
    viol_t v;

    sdram_cmd_decode u_dec (
        .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke),
        .cmd  (cmd)
    );

    assign is_act   = (cmd == CMD_ACT);
    assign is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);
    assign is_pre   = (cmd == CMD_PRE);
    assign any_busy = |busy;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        assign act_hit[b]  = is_act && (ba == 1'(b));
        assign pre_hit[b]  = is_pre && (a10 || (ba == 1'(b))) && open[b];
        assign ap_start[b] = is_rw && a10 && !FULL_PAGE && !any_busy && (ba == 1'(b));

        sdram_bank_track #(.CW(CW), .BL_EFF(BL_EFF), .BW(BW)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .act     (act_hit[b]),
            .pre     (pre_hit[b]),
            .ap_start(ap_start[b]),
            .ap_wr   (cmd == CMD_WR),
            .open    (open[b]),
            .busy    (busy[b]),
            .act_age (act_age[b]),
            .pre_age (pre_age[b]),
            .dal_age (dal_age[b])
        );
    end

    always_comb begin
        v = '0;
        if (is_act) begin
            v.reopen = open[ba];
            v.rc     = act_age[ba]  < LIM_RC;
            v.rrd    = act_age[~ba] < LIM_RRD;
            v.rp     = pre_age[ba]  < LIM_RP;
            v.dal    = dal_age[ba]  < LIM_DAL;
        end
        if (is_rw) begin
            v.rcd     = act_age[ba] < LIM_RCD;
            v.ap_busy = any_busy;
            v.ap_fp   = a10 && FULL_PAGE;
        end
        if (is_pre) begin
            v.ap_busy = any_busy;
            v.ras     = (pre_hit[0] && (act_age[0] < LIM_RAS)) ||
                        (pre_hit[1] && (act_age[1] < LIM_RAS));
        end
    end

    assign cmd_o            = cmd;
    assign flag_rcd         = v.rcd;
    assign flag_rc          = v.rc;
    assign flag_rrd         = v.rrd;
    assign flag_rp          = v.rp;
    assign flag_ras         = v.ras;
    assign flag_dal         = v.dal;
    assign flag_reopen      = v.reopen;
    assign flag_ap_busy     = v.ap_busy;
    assign flag_ap_fullpage = v.ap_fp;

endmodule

// File: rtl/sdram_timing_monitor_chk.sv
module sdram_timing_monitor_chk #(
    parameter int TRCD = 3,
    parameter int TRRD = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       cke,
    input logic       ba,
    input logic       a10,
    input logic [2:0] cmd_o,
    input logic       flag_rcd,
    input logic       flag_rc,
    input logic       flag_rrd,
    input logic       flag_rp,
    input logic       flag_ras,
    input logic       flag_dal,
    input logic       flag_reopen,
    input logic       flag_ap_busy,
    input logic       flag_ap_fullpage
);

    assert_act_flags_on_act_R4: assert property (@(posedge clk) disable iff (rst)
        (flag_rc || flag_reopen || flag_rrd || flag_rp || flag_dal) |-> (cmd_o == 3'd2));

    assert_rcd_on_access_R3: assert property (@(posedge clk) disable iff (rst)
        flag_rcd |-> (cmd_o == 3'd3 || cmd_o == 3'd4));

    assert_ras_on_pre_R9: assert property (@(posedge clk) disable iff (rst)
        flag_ras |-> (cmd_o == 3'd5));

    assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (cs_n || !cke) |-> (cmd_o == 3'd0 && !flag_rcd && !flag_rc && !flag_rrd &&
                            !flag_rp && !flag_ras && !flag_dal && !flag_reopen &&
                            !flag_ap_busy && !flag_ap_fullpage));

    assert_reopen_back_to_back_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cmd_o) == 3'd2 && cmd_o == 3'd2 && ba == $past(ba))
        |-> flag_reopen);

    assert_rrd_back_to_back_R6: assert property (@(posedge clk) disable iff (rst)
        (TRRD > 1 && !$past(rst) && $past(cmd_o) == 3'd2 && cmd_o == 3'd2 &&
         ba != $past(ba)) |-> flag_rrd);

    assert_rcd_back_to_back_R3: assert property (@(posedge clk) disable iff (rst)
        (TRCD > 1 && !$past(rst) && $past(cmd_o) == 3'd2 &&
         (cmd_o == 3'd3 || cmd_o == 3'd4) && ba == $past(ba)) |-> flag_rcd);

    assert_fullpage_needs_ap_R13: assert property (@(posedge clk) disable iff (rst)
        flag_ap_fullpage |-> (a10 && (cmd_o == 3'd3 || cmd_o == 3'd4)));

endmodule

bind sdram_timing_monitor sdram_timing_monitor_chk #(.TRCD(TRCD), .TRRD(TRRD)) u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cke(cke), .ba(ba), .a10(a10), .cmd_o(cmd_o),
    .flag_rcd(flag_rcd), .flag_rc(flag_rc), .flag_rrd(flag_rrd), .flag_rp(flag_rp),
    .flag_ras(flag_ras), .flag_dal(flag_dal), .flag_reopen(flag_reopen),
    .flag_ap_busy(flag_ap_busy), .flag_ap_fullpage(flag_ap_fullpage)
);

// File: tb/sdram_timing_monitor_test.sv
module sdram_timing_monitor_test;

    localparam int CLK_PERIOD = 10;

    // flag vector order: rcd rc rrd rp ras dal reopen ap_busy ap_fp
    localparam logic [8:0] F_NONE = 9'h000;
    localparam logic [8:0] F_RCD  = 9'h100;
    localparam logic [8:0] F_RC   = 9'h080;
    localparam logic [8:0] F_RRD  = 9'h040;
    localparam logic [8:0] F_RP   = 9'h020;
    localparam logic [8:0] F_RAS  = 9'h010;
    localparam logic [8:0] F_DAL  = 9'h008;
    localparam logic [8:0] F_REOP = 9'h004;
    localparam logic [8:0] F_BUSY = 9'h002;
    localparam logic [8:0] F_FP   = 9'h001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic ba = 1'b0, a10 = 1'b0;

    logic [2:0] cmd_o, cmd_fp;
    logic [8:0] fl, fl_fp;
    logic [8:0] got, got_fp;
    logic [2:0] got_cmd;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_timing_monitor uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .ba(ba), .a10(a10), .cmd_o(cmd_o),
        .flag_rcd(fl[8]), .flag_rc(fl[7]), .flag_rrd(fl[6]), .flag_rp(fl[5]),
        .flag_ras(fl[4]), .flag_dal(fl[3]), .flag_reopen(fl[2]),
        .flag_ap_busy(fl[1]), .flag_ap_fullpage(fl[0])
    );

    sdram_timing_monitor #(.BURST_LEN(0)) uut_fp (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .ba(ba), .a10(a10), .cmd_o(cmd_fp),
        .flag_rcd(fl_fp[8]), .flag_rc(fl_fp[7]), .flag_rrd(fl_fp[6]), .flag_rp(fl_fp[5]),
        .flag_ras(fl_fp[4]), .flag_dal(fl_fp[3]), .flag_reopen(fl_fp[2]),
        .flag_ap_busy(fl_fp[1]), .flag_ap_fullpage(fl_fp[0])
    );

    task automatic chk_flags(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s flags actual=%09b expected=%09b", tag, act, exp);
        end
    endtask

    task automatic chk_cmd(input string tag, input logic [2:0] exp);
        n_chk++;
        if (got_cmd !== exp) begin
            n_fail++;
            $display("FAIL %s cmd actual=%0d expected=%0d", tag, got_cmd, exp);
        end
    endtask

    // one command cycle: drive at falling edge, sample before the rising edge
    task automatic cyc(input logic c, input logic [2:0] rcw, input logic b,
                       input logic a, input logic k);
        cs_n = c; {ras_n, cas_n, we_n} = rcw; ba = b; a10 = a; cke = k;
        #1;
        got = fl; got_fp = fl_fp; got_cmd = cmd_o;
        @(negedge clk);
    endtask

    task automatic nop();                           cyc(1'b0, 3'b111, 1'b0, 1'b0, 1'b1); endtask
    task automatic act(input logic b);              cyc(1'b0, 3'b011, b, 1'b0, 1'b1);    endtask
    task automatic rd(input logic b, input logic a); cyc(1'b0, 3'b101, b, a, 1'b1);      endtask
    task automatic wr(input logic b, input logic a); cyc(1'b0, 3'b100, b, a, 1'b1);      endtask
    task automatic pre(input logic b, input logic a); cyc(1'b0, 3'b010, b, a, 1'b1);     endtask
    task automatic nops(input int n); for (int i = 0; i < n; i++) nop(); endtask

    task automatic do_reset();
        cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b111; cke = 1'b1; ba = 1'b0; a10 = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_decode();
        do_reset();
        nop();            chk_cmd("R1 nop", 3'd1); chk_flags("R1 reset quiet", got, F_NONE);
        act(1'b0);        chk_cmd("R1 act", 3'd2); chk_flags("R1 fresh act", got, F_NONE);
        rd(1'b1, 1'b0);   chk_cmd("R1 read", 3'd3);
        wr(1'b1, 1'b0);   chk_cmd("R1 write", 3'd4);
        cyc(1'b0, 3'b110, 1'b0, 1'b0, 1'b1); chk_cmd("R1 burst stop", 3'd6);
        cyc(1'b0, 3'b001, 1'b0, 1'b0, 1'b1); chk_cmd("R1 other", 3'd7);
        pre(1'b1, 1'b0);  chk_cmd("R1 precharge", 3'd5);
    endtask

    task automatic t_rcd();
        do_reset();
        act(1'b0); nop();
        rd(1'b0, 1'b0); chk_flags("R3 read at 2", got, F_RCD);
        wr(1'b0, 1'b0); chk_flags("R3 write at 3", got, F_NONE);
    endtask

    task automatic t_rrd();
        do_reset();
        act(1'b0);
        act(1'b1); chk_flags("R6 act other bank at 1", got, F_RRD);
        do_reset();
        act(1'b0); nop();
        act(1'b1); chk_flags("R6 act other bank at 2", got, F_NONE);
    endtask

    task automatic t_rc_rp_reopen();
        do_reset();
        act(1'b0); nops(5);
        pre(1'b0, 1'b0); chk_flags("R9 pre at tRAS", got, F_NONE);
        nop();
        act(1'b0); chk_flags("R7 R4 act early", got, F_RC | F_RP);
        do_reset();
        act(1'b0); nops(5); pre(1'b0, 1'b0); nops(2);
        act(1'b0); chk_flags("R7 R4 act on time", got, F_NONE);
        do_reset();
        act(1'b0); nops(8);
        act(1'b0); chk_flags("R5 act open bank", got, F_REOP);
    endtask

    task automatic t_ras_target();
        do_reset();
        act(1'b0); nops(2);
        pre(1'b0, 1'b0); chk_flags("R9 pre at 3", got, F_RAS);
        do_reset();
        act(1'b0); nop(); act(1'b1); nops(5);
        pre(1'b0, 1'b1); chk_flags("R8 pre all", got, F_NONE);
        act(1'b0); chk_flags("R8 bank0 closed by pre all", got, F_RP);
        do_reset();
        act(1'b0); nop(); act(1'b1); nops(5);
        pre(1'b1, 1'b0); chk_flags("R8 pre bank1", got, F_NONE);
        act(1'b0); chk_flags("R8 bank0 still open", got, F_REOP);
    endtask

    task automatic t_ap_read();
        do_reset();
        act(1'b0); nops(2);
        rd(1'b0, 1'b1);  chk_flags("R10 ap read start", got, F_NONE);
        wr(1'b1, 1'b0);  chk_flags("R10 write in window", got, F_BUSY);
        pre(1'b1, 1'b0); chk_flags("R10 pre in window", got, F_BUSY);
        nop();
        rd(1'b1, 1'b0);  chk_flags("R10 read after window", got, F_NONE);
        act(1'b0);       chk_flags("R11 act after ap read", got, F_RC | F_RP);
    endtask

    task automatic t_dal();
        do_reset();
        act(1'b0); nops(2);
        wr(1'b0, 1'b1); chk_flags("R12 ap write start", got, F_NONE);
        nops(6);
        act(1'b0); chk_flags("R12 act before tDAL", got, F_DAL);
        do_reset();
        act(1'b0); nops(2); wr(1'b0, 1'b1); nops(7);
        act(1'b0); chk_flags("R12 act at tDAL", got, F_NONE);
    endtask

    task automatic t_fullpage();
        do_reset();
        act(1'b0); nops(2);
        rd(1'b0, 1'b1);
        chk_flags("R13 full page ap", got_fp, F_FP);
        chk_flags("R13 normal burst ap", got, F_NONE);
        wr(1'b0, 1'b0);
        chk_flags("R13 no window opened", got_fp, F_NONE);
    endtask

    task automatic t_deselect();
        do_reset();
        act(1'b0);
        cyc(1'b1, 3'b011, 1'b0, 1'b0, 1'b1);
        chk_cmd("R2 deselect", 3'd0); chk_flags("R2 deselect quiet", got, F_NONE);
        cyc(1'b0, 3'b011, 1'b1, 1'b0, 1'b0);
        chk_cmd("R2 cke low", 3'd0); chk_flags("R2 cke low quiet", got, F_NONE);
        rd(1'b0, 1'b0); chk_flags("R2 no reactivation of bank0", got, F_NONE);
        act(1'b1);      chk_flags("R2 bank1 untouched", got, F_NONE);
    endtask

    initial begin
        t_reset_decode();
        t_rcd();
        t_rrd();
        t_rc_rp_reopen();
        t_ras_target();
        t_ap_read();
        t_dal();
        t_fullpage();
        t_deselect();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule